// File: doc/BRIEF.md
# Dual-Channel Serial Interrupt Pending Logic

This block keeps the interrupt-pending state of a two-channel serial controller. Each channel, A and B, feeds it one-cycle event strobes: a character arrived, the receiver overran, a framing error, a parity error, an end of frame, and the transmit buffer went empty. It also feeds six level inputs whose changes are status events. Per-channel settings decide which events become pending bits. The block drives one active-low interrupt request and a pending byte with both channels' bits, and it also drives an encoded highest-priority source.

Errors are grouped as special conditions, and these always raise a receive interrupt while reception interrupts are on. Ordinary characters interrupt according to a 2-bit receive mode. The host clears pending state with per-channel command strobes. Pending bits live in registers. The request output is a combinational function of those registers and the master enable.

Top module: `sio_irq_pend`

## Requirements
- R1: After reset the pending byte is 0x00, `irq_n` is 1 and `top_src` is 0.
- R2: A special condition is an overrun, a framing error, an end of frame, or a parity error when that channel's `pe_sc_en` is 1. It sets the channel's rx pending bit in receive modes 01, 10 and 11. A parity error with `pe_sc_en` at 0 sets nothing.
- R3: In receive mode 00 neither characters nor special conditions set the rx pending bit.
- R4: In receive mode 10 every character sets rx pending. `cmd_rd_char` clears the character part of it. A latched special condition keeps the bit set.
- R5: In receive mode 01 only the first character after reset or after `cmd_arm_rx` sets rx pending. Later characters are ignored until `cmd_arm_rx` re-arms the channel.
- R6: In receive mode 11 characters are ignored and only special conditions set rx pending.
- R7: A `ev_txe` strobe sets tx pending only when `tx_ie` is 1. `cmd_clr_tx` clears it.
- R8: A change on a status line whose `ext_en` bit (same index) is 1 sets status pending when `ext_ie` is 1. Changes on disabled lines are ignored. While status pending is set, the reference levels are frozen. `cmd_clr_ext` clears the bit and reloads the levels, and a line that differs from its frozen level at the clear raises the bit again.
- R9: `cmd_clr_err` clears the latched special condition. A set and a clear of the same bit in one cycle leave it set.
- R10: Pending byte layout: bit5 A rx, bit4 A tx, bit3 A status, bit2 B rx, bit1 B tx, bit0 B status; bits 7:6 are 0. In every vector port, index 1 is channel A and index 0 is channel B. `rx_mode[3:2]` is A and `rx_mode[1:0]` is B. `ext_en`/`ext_lvl` bits 11:6 are A and bits 5:0 are B.
- R11: `irq_n` is 0 exactly when `mie` is 1 and some pending bit is set.
- R12: `top_src` codes the highest pending source: 1 A rx, 2 A tx, 3 A status, 4 B rx, 5 B tx, 6 B status, 0 none. Channel A ranks above B, and within a channel rx ranks above tx, which ranks above status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mie | input | 1 | Master interrupt enable |
| rx_mode | input | 4 | Receive interrupt mode, 2 bits per channel |
| pe_sc_en | input | 2 | Parity error counts as special condition |
| tx_ie | input | 2 | Transmit interrupt enable |
| ext_ie | input | 2 | Status interrupt enable |
| ext_en | input | 2*N_EXT | Per-line status change enables |
| ev_char | input | 2 | Character received strobe |
| ev_ovr | input | 2 | Receiver overrun strobe |
| ev_fe | input | 2 | Framing error strobe |
| ev_pe | input | 2 | Parity error strobe |
| ev_eof | input | 2 | End of frame strobe |
| ev_txe | input | 2 | Transmit buffer empty strobe |
| ext_lvl | input | 2*N_EXT | Status line levels |
| cmd_rd_char | input | 2 | Clear character-received pending |
| cmd_clr_err | input | 2 | Clear latched special condition |
| cmd_clr_tx | input | 2 | Clear tx pending |
| cmd_clr_ext | input | 2 | Clear status pending and reload levels |
| cmd_arm_rx | input | 2 | Re-arm first-character mode |
| irq_n | output | 1 | Active-low interrupt request |
| pend_byte | output | 8 | Packed pending bits |
| top_src | output | 3 | Highest-priority pending source |

## Verification
A strobe or command that is present at a rising edge changes the pending byte and `top_src` right after that edge, one cycle of latency. `irq_n` follows the new pending state on the same edge, and it follows `mie` with no clock at all. The bench model advances on each rising edge from the inputs driven at the previous falling edge. It compares all three outputs 2 ns after that edge. Directed checks are made at the next falling edge, and `mie` checks are made 1 ns after the change, once the outputs have settled.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;

  localparam int NCH = 2;

  typedef enum logic [1:0] {
    RXM_OFF   = 2'b00,
    RXM_FIRST = 2'b01,
    RXM_ALL   = 2'b10,
    RXM_SC    = 2'b11
  } rx_mode_e;

  // Error grouping: parity only counts when its own enable is on.
  function automatic logic is_special(logic ovr, logic fe, logic eof,
                                      logic pe, logic pe_en);
    return ovr | fe | eof | (pe & pe_en);
  endfunction

  // Highest set bit of the 6-bit pending field wins; code = 6 - index.
  function automatic logic [2:0] pick_src(logic [5:0] p);
    logic [2:0] r;
    r = 3'd0;
    for (int i = 0; i < 6; i++) begin
      if (p[i]) r = 3'(6 - i);
    end
    return r;
  endfunction

endpackage

// File: rtl/sio_irq_chan.sv
module sio_irq_chan
  import sio_irq_pkg::*;
#(
  parameter int N_EXT = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       rx_mode,
  input  logic             pe_sc_en,
  input  logic             tx_ie,
  input  logic             ext_ie,
  input  logic [N_EXT-1:0] ext_en,
  input  logic             ev_char,
  input  logic             ev_ovr,
  input  logic             ev_fe,
  input  logic             ev_pe,
  input  logic             ev_eof,
  input  logic             ev_txe,
  input  logic [N_EXT-1:0] ext_lvl,
  input  logic             cmd_rd_char,
  input  logic             cmd_clr_err,
  input  logic             cmd_clr_tx,
  input  logic             cmd_clr_ext,
  input  logic             cmd_arm_rx,
  output logic             rx_pend,
  output logic             tx_pend,
  output logic             ext_pend
);

  rx_mode_e mode;
  logic chr_q, sc_q, tx_q, ext_q, armed_q;
  logic [N_EXT-1:0] snap_q;

  // Named internal events.
  logic sc_hit, char_hit, first_taken, tx_hit, ext_hit, ext_hold;
  logic [N_EXT-1:0] ext_edge;

  assign mode        = rx_mode_e'(rx_mode);
  assign sc_hit      = (mode != RXM_OFF) &&
                       is_special(ev_ovr, ev_fe, ev_eof, ev_pe, pe_sc_en);
  assign char_hit    = ev_char && ((mode == RXM_ALL) ||
                                   ((mode == RXM_FIRST) && armed_q));
  assign first_taken = char_hit && (mode == RXM_FIRST);
  assign tx_hit      = ev_txe && tx_ie;
  assign ext_edge    = (ext_lvl ^ snap_q) & ext_en;
  assign ext_hit     = ext_ie && (|ext_edge);
  assign ext_hold    = ext_q && !cmd_clr_ext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chr_q   <= 1'b0;
      sc_q    <= 1'b0;
      tx_q    <= 1'b0;
      ext_q   <= 1'b0;
      armed_q <= 1'b1;
      snap_q  <= '0;
    end else begin
      chr_q   <= char_hit | (chr_q & ~cmd_rd_char);
      sc_q    <= sc_hit   | (sc_q  & ~cmd_clr_err);
      tx_q    <= tx_hit   | (tx_q  & ~cmd_clr_tx);
      ext_q   <= ext_hit  | ext_hold;
      armed_q <= cmd_arm_rx | (armed_q & ~first_taken);
      if (!ext_hold) snap_q <= ext_lvl;
    end
  end

  assign rx_pend  = chr_q | sc_q;
  assign tx_pend  = tx_q;
  assign ext_pend = ext_q;

endmodule

// File: rtl/sio_irq_prio.sv
module sio_irq_prio
  import sio_irq_pkg::*;
(
  input  logic [5:0] pend,
  input  logic       mie,
  output logic       irq_n,
  output logic [2:0] top_src
);

  logic any_pend;

  assign any_pend = |pend;
  assign irq_n    = ~(mie & any_pend);
  assign top_src  = pick_src(pend);

endmodule

// File: rtl/sio_irq_pend.sv
module sio_irq_pend
  import sio_irq_pkg::*;
#(
  parameter int N_EXT = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   mie,
  input  logic [2*NCH-1:0]       rx_mode,
  input  logic [NCH-1:0]         pe_sc_en,
  input  logic [NCH-1:0]         tx_ie,
  input  logic [NCH-1:0]         ext_ie,
  input  logic [NCH*N_EXT-1:0]   ext_en,
  input  logic [NCH-1:0]         ev_char,
  input  logic [NCH-1:0]         ev_ovr,
  input  logic [NCH-1:0]         ev_fe,
  input  logic [NCH-1:0]         ev_pe,
  input  logic [NCH-1:0]         ev_eof,
  input  logic [NCH-1:0]         ev_txe,
  input  logic [NCH*N_EXT-1:0]   ext_lvl,
  input  logic [NCH-1:0]         cmd_rd_char,
  input  logic [NCH-1:0]         cmd_clr_err,
  input  logic [NCH-1:0]         cmd_clr_tx,
  input  logic [NCH-1:0]         cmd_clr_ext,
  input  logic [NCH-1:0]         cmd_arm_rx,
  output logic                   irq_n,
  output logic [7:0]             pend_byte,
  output logic [2:0]             top_src
);

  localparam int PW = 3 * NCH;

  logic [NCH-1:0] rx_p, tx_p, ext_p;
  logic [PW-1:0]  pend_bits;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    sio_irq_chan #(.N_EXT(N_EXT)) u_ch (
      .clk         (clk),
      .rst_n       (rst_n),
      .rx_mode     (rx_mode[2*c +: 2]),
      .pe_sc_en    (pe_sc_en[c]),
      .tx_ie       (tx_ie[c]),
      .ext_ie      (ext_ie[c]),
      .ext_en      (ext_en[c*N_EXT +: N_EXT]),
      .ev_char     (ev_char[c]),
      .ev_ovr      (ev_ovr[c]),
      .ev_fe       (ev_fe[c]),
      .ev_pe       (ev_pe[c]),
      .ev_eof      (ev_eof[c]),
      .ev_txe      (ev_txe[c]),
      .ext_lvl     (ext_lvl[c*N_EXT +: N_EXT]),
      .cmd_rd_char (cmd_rd_char[c]),
      .cmd_clr_err (cmd_clr_err[c]),
      .cmd_clr_tx  (cmd_clr_tx[c]),
      .cmd_clr_ext (cmd_clr_ext[c]),
      .cmd_arm_rx  (cmd_arm_rx[c]),
      .rx_pend     (rx_p[c]),
      .tx_pend     (tx_p[c]),
      .ext_pend    (ext_p[c])
    );
    // Channel c occupies bits 3c+2 (rx), 3c+1 (tx), 3c (status).
    assign pend_bits[3*c +: 3] = {rx_p[c], tx_p[c], ext_p[c]};
  end

  assign pend_byte = {{(8-PW){1'b0}}, pend_bits};

  sio_irq_prio u_prio (
    .pend    (pend_bits),
    .mie     (mie),
    .irq_n   (irq_n),
    .top_src (top_src)
  );

endmodule

// File: rtl/sio_irq_pend_chk.sv
module sio_irq_pend_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mie,
  input logic [3:0] rx_mode,
  input logic [1:0] ext_ie,
  input logic [1:0] ev_txe,
  input logic [1:0] cmd_clr_tx,
  input logic       irq_n,
  input logic [7:0] pend_byte,
  input logic [2:0] top_src
);

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !mie |-> irq_n);  // R11
  AST_IRQ_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
    (mie && pend_byte != 8'h00) |-> !irq_n);  // R11
  AST_HIGH_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    pend_byte[7:6] == 2'b00);  // R10
  AST_TX_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_clr_tx[1] && !ev_txe[1]) |=> !pend_byte[4]);  // R7
  AST_RX_MODE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_mode[3:2] == 2'b00 && !pend_byte[5]) |=> !pend_byte[5]);  // R3
  AST_EXT_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_ie[0] && !pend_byte[0]) |=> !pend_byte[0]);  // R8
  AST_NO_SRC_IFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_byte[5:0] == 6'd0) == (top_src == 3'd0));  // R12

endmodule

bind sio_irq_pend sio_irq_pend_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mie        (mie),
  .rx_mode    (rx_mode),
  .ext_ie     (ext_ie),
  .ev_txe     (ev_txe),
  .cmd_clr_tx (cmd_clr_tx),
  .irq_n      (irq_n),
  .pend_byte  (pend_byte),
  .top_src    (top_src)
);

// File: tb/sio_irq_pend_bench.sv
module sio_irq_pend_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mie = 1'b1;
  logic [3:0]  rx_mode = 4'b1010;
  logic [1:0]  pe_sc_en = 2'b00, tx_ie = 2'b00, ext_ie = 2'b00;
  logic [11:0] ext_en = '0, ext_lvl = '0;
  logic [1:0]  ev_char = '0, ev_ovr = '0, ev_fe = '0, ev_pe = '0, ev_eof = '0, ev_txe = '0;
  logic [1:0]  cmd_rd_char = '0, cmd_clr_err = '0, cmd_clr_tx = '0, cmd_clr_ext = '0, cmd_arm_rx = '0;
  logic        irq_n;
  logic [7:0]  pend_byte;
  logic [2:0]  top_src;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  string phase = "R1";

  always #5 clk = ~clk;

  sio_irq_pend u_sio_irq_pend (
    .clk(clk), .rst_n(rst_n), .mie(mie), .rx_mode(rx_mode),
    .pe_sc_en(pe_sc_en), .tx_ie(tx_ie), .ext_ie(ext_ie), .ext_en(ext_en),
    .ev_char(ev_char), .ev_ovr(ev_ovr), .ev_fe(ev_fe), .ev_pe(ev_pe),
    .ev_eof(ev_eof), .ev_txe(ev_txe), .ext_lvl(ext_lvl),
    .cmd_rd_char(cmd_rd_char), .cmd_clr_err(cmd_clr_err),
    .cmd_clr_tx(cmd_clr_tx), .cmd_clr_ext(cmd_clr_ext),
    .cmd_arm_rx(cmd_arm_rx), .irq_n(irq_n), .pend_byte(pend_byte),
    .top_src(top_src)
  );

  // Behavioural reference: one entry per channel, index 1 = A, 0 = B.
  bit m_chr[2], m_sc[2], m_tx[2], m_ex[2], m_arm[2];
  logic [5:0] m_snap[2];

  function automatic logic [7:0] model_byte();
    logic [7:0] b = 8'h00;
    if (m_chr[1] || m_sc[1]) b[5] = 1;
    if (m_tx[1]) b[4] = 1;
    if (m_ex[1]) b[3] = 1;
    if (m_chr[0] || m_sc[0]) b[2] = 1;
    if (m_tx[0]) b[1] = 1;
    if (m_ex[0]) b[0] = 1;
    return b;
  endfunction

  function automatic logic [2:0] model_top(logic [7:0] b);
    // Scan sources in rank order: A rx, A tx, A st, B rx, B tx, B st.
    for (int k = 1; k <= 6; k++) if (b[6 - k]) return 3'(k);
    return 3'd0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        m_chr[c] = 0; m_sc[c] = 0; m_tx[c] = 0; m_ex[c] = 0;
        m_arm[c] = 1; m_snap[c] = '0;
      end
    end else begin
      for (int c = 0; c < 2; c++) begin
        int md;
        bit sc, ch, hit;
        logic [5:0] lv;
        md  = int'(rx_mode[2*c +: 2]);
        sc  = (md != 0) && (ev_ovr[c] || ev_fe[c] || ev_eof[c] || (ev_pe[c] && pe_sc_en[c]));
        ch  = ev_char[c] && (md == 2 || (md == 1 && m_arm[c]));
        lv  = ext_lvl[6*c +: 6];
        hit = ext_ie[c] && (((lv ^ m_snap[c]) & ext_en[6*c +: 6]) != 0);
        if (!(m_ex[c] && !cmd_clr_ext[c])) m_snap[c] = lv;
        if (hit) m_ex[c] = 1; else if (cmd_clr_ext[c]) m_ex[c] = 0;
        if (cmd_arm_rx[c]) m_arm[c] = 1; else if (md == 1 && ch) m_arm[c] = 0;
        if (ch) m_chr[c] = 1; else if (cmd_rd_char[c]) m_chr[c] = 0;
        if (sc) m_sc[c] = 1; else if (cmd_clr_err[c]) m_sc[c] = 0;
        if (ev_txe[c] && tx_ie[c]) m_tx[c] = 1; else if (cmd_clr_tx[c]) m_tx[c] = 0;
      end
    end
    #2;
    if (!done) begin
      logic [7:0] eb;
      logic ei;
      eb = model_byte();
      ei = !(mie && eb != 0);
      n_chk++;
      if (pend_byte !== eb || irq_n !== ei || top_src !== model_top(eb)) begin
        n_fail++;
        $display("FAIL %s model: byte=%h irq_n=%b top=%0d expected byte=%h irq_n=%b top=%0d",
                 phase, pend_byte, irq_n, top_src, eb, ei, model_top(eb));
      end
    end
  end

  task automatic chk(string tag, logic [7:0] eb, logic ei, logic [2:0] et);
    n_chk++;
    if (pend_byte !== eb || irq_n !== ei || top_src !== et) begin
      n_fail++;
      $display("FAIL %s: byte=%h irq_n=%b top=%0d expected byte=%h irq_n=%b top=%0d",
               tag, pend_byte, irq_n, top_src, eb, ei, et);
    end
  endtask

  task automatic nxt();
    @(negedge clk);
  endtask

  task automatic clear_strobes();
    ev_char = '0; ev_ovr = '0; ev_fe = '0; ev_pe = '0; ev_eof = '0; ev_txe = '0;
    cmd_rd_char = '0; cmd_clr_err = '0; cmd_clr_tx = '0; cmd_clr_ext = '0; cmd_arm_rx = '0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) nxt();
    rst_n = 1;
    nxt();
    chk("R1 reset", 8'h00, 1, 0);

    phase = "R2";
    ev_ovr[1] = 1; nxt(); clear_strobes();
    chk("R2 R10 A overrun", 8'h20, 0, 1);
    mie = 0; #1 chk("R11 mie off", 8'h20, 1, 1);
    nxt(); mie = 1; #1 chk("R11 mie on", 8'h20, 0, 1);
    nxt();
    ev_pe[0] = 1; nxt(); clear_strobes();
    chk("R2 parity not special", 8'h20, 0, 1);
    pe_sc_en[0] = 1; ev_pe[0] = 1; nxt(); clear_strobes();
    chk("R2 parity special", 8'h24, 0, 1);

    phase = "R9";
    cmd_clr_err = 2'b11; nxt(); clear_strobes();
    chk("R9 reset error", 8'h00, 1, 0);

    phase = "R3";
    rx_mode[3:2] = 2'b00; ev_char[1] = 1; ev_ovr[1] = 1; nxt(); clear_strobes();
    chk("R3 mode off", 8'h00, 1, 0);

    phase = "R4";
    rx_mode[3:2] = 2'b10;
    ev_char[1] = 1; nxt(); clear_strobes(); chk("R4 char", 8'h20, 0, 1);
    cmd_rd_char[1] = 1; nxt(); clear_strobes(); chk("R4 read", 8'h00, 1, 0);
    ev_char[1] = 1; nxt(); clear_strobes(); chk("R4 char again", 8'h20, 0, 1);
    cmd_rd_char[1] = 1; nxt(); clear_strobes();
    ev_char[1] = 1; ev_fe[1] = 1; nxt(); clear_strobes();
    cmd_rd_char[1] = 1; nxt(); clear_strobes(); chk("R4 sc holds", 8'h20, 0, 1);
    cmd_clr_err[1] = 1; ev_fe[1] = 1; nxt(); clear_strobes();
    chk("R9 set beats clear", 8'h20, 0, 1);
    cmd_clr_err[1] = 1; nxt(); clear_strobes(); chk("R9 cleared", 8'h00, 1, 0);

    phase = "R5";
    rx_mode[3:2] = 2'b01;
    ev_char[1] = 1; nxt(); clear_strobes(); chk("R5 first", 8'h20, 0, 1);
    cmd_rd_char[1] = 1; nxt(); clear_strobes();
    ev_char[1] = 1; nxt(); clear_strobes(); chk("R5 second ignored", 8'h00, 1, 0);
    cmd_arm_rx[1] = 1; nxt(); clear_strobes(); chk("R5 arm only", 8'h00, 1, 0);
    ev_char[1] = 1; nxt(); clear_strobes(); chk("R5 rearmed", 8'h20, 0, 1);
    cmd_rd_char[1] = 1; nxt(); clear_strobes();

    phase = "R6";
    rx_mode[3:2] = 2'b11;
    ev_char[1] = 1; nxt(); clear_strobes(); chk("R6 char ignored", 8'h00, 1, 0);
    ev_eof[1] = 1; nxt(); clear_strobes(); chk("R6 eof", 8'h20, 0, 1);
    cmd_clr_err[1] = 1; nxt(); clear_strobes();

    phase = "R7";
    ev_txe[1] = 1; nxt(); clear_strobes(); chk("R7 tx disabled", 8'h00, 1, 0);
    tx_ie[1] = 1; ev_txe[1] = 1; nxt(); clear_strobes(); chk("R7 tx", 8'h10, 0, 2);
    cmd_clr_tx[1] = 1; nxt(); clear_strobes(); chk("R7 tx clear", 8'h00, 1, 0);

    phase = "R8";
    ext_ie[0] = 1; ext_en[5:0] = 6'b000001;
    ext_lvl[1] = 1; nxt(); nxt(); chk("R8 disabled line", 8'h00, 1, 0);
    ext_lvl[0] = 1; nxt(); chk("R8 edge", 8'h01, 0, 6);
    ext_lvl[0] = 0; nxt(); chk("R8 frozen", 8'h01, 0, 6);
    cmd_clr_ext[0] = 1; nxt(); clear_strobes(); chk("R8 differs at clear", 8'h01, 0, 6);
    cmd_clr_ext[0] = 1; nxt(); clear_strobes(); chk("R8 cleared", 8'h00, 1, 0);

    phase = "R12";
    rx_mode[3:2] = 2'b10; tx_ie[0] = 1; ext_ie[1] = 1; ext_en[11:6] = 6'b000001;
    ev_txe[0] = 1; nxt(); clear_strobes(); chk("R12 B tx", 8'h02, 0, 5);
    ext_lvl[6] = 1; nxt(); chk("R12 A status", 8'h0A, 0, 3);
    ev_char[1] = 1; nxt(); clear_strobes(); chk("R12 A rx", 8'h2A, 0, 1);
    cmd_rd_char[1] = 1; nxt(); clear_strobes(); chk("R12 back to A status", 8'h0A, 0, 3);
    cmd_clr_ext[1] = 1; nxt(); clear_strobes(); chk("R12 back to B tx", 8'h02, 0, 5);

    phase = "random";
    for (int i = 0; i < 4000; i++) begin
      nxt();
      clear_strobes();
      if (i % 64 == 0) begin
        rx_mode = 4'($urandom); pe_sc_en = 2'($urandom); tx_ie = 2'($urandom);
        ext_ie = 2'($urandom); ext_en = 12'($urandom); mie = 1'($urandom);
      end
      for (int c = 0; c < 2; c++) begin
        ev_char[c] = ($urandom_range(0, 3) == 0);
        ev_ovr[c] = ($urandom_range(0, 15) == 0);
        ev_fe[c] = ($urandom_range(0, 15) == 0);
        ev_pe[c] = ($urandom_range(0, 7) == 0);
        ev_eof[c] = ($urandom_range(0, 15) == 0);
        ev_txe[c] = ($urandom_range(0, 7) == 0);
        cmd_rd_char[c] = ($urandom_range(0, 3) == 0);
        cmd_clr_err[c] = ($urandom_range(0, 7) == 0);
        cmd_clr_tx[c] = ($urandom_range(0, 5) == 0);
        cmd_clr_ext[c] = ($urandom_range(0, 5) == 0);
        cmd_arm_rx[c] = ($urandom_range(0, 9) == 0);
      end
      if ($urandom_range(0, 5) == 0) ext_lvl[$urandom_range(0, 11)] ^= 1'b1;
    end
    nxt(); clear_strobes(); nxt(); nxt();
    finish_run();
  end

endmodule